// File: doc/BRIEF.md
# Scan Segment Insertion Bit

This block is one switch point in a reconfigurable scan network. It holds one control bit with two stages. The shift stage sits in the serial chain. The update stage holds the configuration that is in force. When the update stage is 1, a client segment hangs off the `seg_si`/`seg_so` pair and is spliced into the active chain. When it is 0, the segment is bypassed and only the control bit remains in the path.

The parameter `MUX_BEFORE` sets where the multiplexer sits:

- When it is 0, the multiplexer follows both the control bit and the segment, so the control bit always feeds the segment.
- When it is 1, the multiplexer feeds the control bit, so the segment sits ahead of it.

Hierarchy is built by wiring `seg_sel` of one instance into `sel` of the instances and registers inside its segment. An excluded inner bit therefore holds both of its stages untouched until its parent opens again.

Top module: `scan_insert_bit`

## Requirements
- R1: While `rst_n` is low, both stages clear to 0. The segment is therefore excluded and the instance forms a one-bit chain.
- R2: On a clock edge with `sel` and `update_en` both high, the update stage takes the value of the shift stage. An update value of 1 includes the segment and 0 bypasses it.
- R3: The update stage, and with it the chain length, changes only on an edge with `sel` and `update_en` high. Shifting new values into the shift stage alone leaves the path as it was.
- R4: On an edge with `sel` and `capture_en` high, the shift stage loads the update value, so the inclusion state can be read out. Capture takes precedence over `shift_en` in the same cycle.
- R5: On an edge with `sel` and `shift_en` high and `capture_en` low, the shift stage loads its chain input. That input is `scan_in` when `MUX_BEFORE` is 0. When `MUX_BEFORE` is 1 it is `seg_so` with the segment open and `scan_in` with it closed.
- R6: With `MUX_BEFORE` 0, `seg_si` carries the shift stage, and `scan_out` is `seg_so` when open and the shift stage when closed.
- R7: With `MUX_BEFORE` 1, `seg_si` carries `scan_in` and `scan_out` is always the shift stage.
- R8: `seg_sel` is high exactly when `sel` is high and the segment is open. In a nest, an inner bit whose parent is closed keeps its update value, and that value takes effect again when the parent reopens.
- R9: While `sel` is low, neither stage changes, whatever the capture, shift and update inputs do.
- R10: Capture and update in the same cycle exchange the two stages. The update stage takes the old shift value and the shift stage takes the old update value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | This bit lies on the active chain |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data from upstream |
| scan_out | output | 1 | Serial data to downstream |
| seg_si | output | 1 | Serial data into the client segment |
| seg_so | input | 1 | Serial data back from the client segment |
| seg_sel | output | 1 | Select for the client segment |

## Verification
Capture and update can fall in the same cycle, and so can capture and shift. The bench provokes the first by shifting a 1 into a closed bit and raising capture and update on one edge. It judges the result by the chain length that follows: the outer bit has opened while its inner bit stays closed. The second is provoked during a readback. Capture and shift are raised together on a nest with both bits open, and the captured 1s must then appear at the positions of the two control bits as the chain is shifted out. Chain length is measured for every open and closed combination of the two-level nest by timing a single marker bit through the chain.

// File: rtl/scan_insert_bit.sv
module scan_insert_bit #(
  parameter bit MUX_BEFORE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic scan_in,
  output logic scan_out,
  output logic seg_si,
  input  logic seg_so,
  output logic seg_sel
);

  logic shift_q;
  logic open_q;
  logic shift_d;

  generate
    if (MUX_BEFORE) begin : g_pre
      assign shift_d  = open_q ? seg_so : scan_in;
      assign seg_si   = scan_in;
      assign scan_out = shift_q;
    end else begin : g_post
      assign shift_d  = scan_in;
      assign seg_si   = shift_q;
      assign scan_out = open_q ? seg_so : shift_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shift_q <= 1'b0;
    else if (sel) begin
      if (capture_en)
        shift_q <= open_q;
      else if (shift_en)
        shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      open_q <= 1'b0;
    else if (sel && update_en)
      open_q <= shift_q;
  end

  assign seg_sel = sel & open_q;

endmodule

module scan_insert_bit_chk #(
  parameter bit MUX_BEFORE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic capture_en,
  input logic shift_en,
  input logic update_en,
  input logic scan_in,
  input logic shift_q,
  input logic open_q
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!open_q && !shift_q));

  assert_update_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update_en) |=> (open_q == $past(shift_q)));

  assert_path_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && update_en) |=> $stable(open_q));

  assert_capture_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && capture_en) |=> (shift_q == $past(open_q)));

  assert_post_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!MUX_BEFORE && sel && shift_en && !capture_en) |=> (shift_q == $past(scan_in)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(shift_q) && $stable(open_q)));

endmodule

bind scan_insert_bit scan_insert_bit_chk #(.MUX_BEFORE(MUX_BEFORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .capture_en(capture_en),
  .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
  .shift_q(shift_q), .open_q(open_q)
);

// File: tb/scan_insert_bit_tb.sv
module scan_insert_bit_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sel, cap, sh, upd, si;
  logic a_so, a_seg_si, a_seg_sel;
  logic b_so, b_seg_si, b_seg_sel;
  logic [2:0] inner;
  logic [1:0] tail;
  int checks = 0;
  int fails  = 0;

  scan_insert_bit #(.MUX_BEFORE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture_en(cap), .shift_en(sh),
    .update_en(upd), .scan_in(si), .scan_out(a_so), .seg_si(a_seg_si),
    .seg_so(tail[1]), .seg_sel(a_seg_sel)
  );

  scan_insert_bit #(.MUX_BEFORE(1'b1)) inner_i (
    .clk(clk), .rst_n(rst_n), .sel(a_seg_sel), .capture_en(cap), .shift_en(sh),
    .update_en(upd), .scan_in(a_seg_si), .scan_out(b_so), .seg_si(b_seg_si),
    .seg_so(inner[2]), .seg_sel(b_seg_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inner <= '0;
    else if (b_seg_sel && sh && !cap) inner <= {inner[1:0], b_seg_si};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail <= '0;
    else if (a_seg_sel && sh && !cap) tail <= {tail[0], b_so};
  end

  // {program bits (bit0 nearest scan_in), program length, expected chain length}
  localparam logic [23:0] VEC [6] = '{
    {8'd1, 8'd1, 8'd4},
    {8'd3, 8'd4, 8'd7},
    {8'd1, 8'd7, 8'd4},
    {8'd2, 8'd4, 8'd1},
    {8'd1, 8'd1, 8'd7},
    {8'd0, 8'd7, 8'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic s, input logic u, input logic d);
    cap = c; sh = s; upd = u; si = d;
    @(negedge clk);
    cap = 1'b0; sh = 1'b0; upd = 1'b0; si = 1'b0;
  endtask

  task automatic shift_vec(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) step(1'b0, 1'b1, 1'b0, v[i]);
  endtask

  task automatic measure(output int len);
    len = 0;
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    for (int k = 1; k <= 24; k++) begin
      if (a_so && len == 0) len = k;
      if (k < 24) step(1'b0, 1'b1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int len;
    rst_n = 1'b0; sel = 1'b1; cap = 1'b0; sh = 1'b0; upd = 1'b0; si = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset leaves the outer bit closed and the readback at 0
    check(a_so == 1'b0, "R1 scan_out after reset", a_so, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check(a_so == 1'b0, "R1 R4 captured value after reset", a_so, 0);
    measure(len);
    check(len == 1, "R1 chain length after reset", len, 1);

    // R2 R6 R7 R8: walk open/closed combinations of the two-level nest
    for (int i = 0; i < 6; i++) begin
      shift_vec(VEC[i][23:16], int'(VEC[i][15:8]));
      step(1'b0, 1'b0, 1'b1, 1'b0);
      measure(len);
      check(len == int'(VEC[i][7:0]), $sformatf("R2 R6 R7 R8 vector %0d chain length", i),
            len, int'(VEC[i][7:0]));
    end

    // R9: deselected bit ignores shift and update
    sel = 1'b0;
    shift_vec(8'd1, 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    sel = 1'b1;
    measure(len);
    check(len == 1, "R9 chain length after deselected update", len, 1);

    // R3: shifting without update keeps the path
    shift_vec(8'd1, 1);
    measure(len);
    check(len == 1, "R3 chain length after shift without update", len, 1);

    // R4: capture wins over shift; readback of both control bits
    shift_vec(8'd1, 1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    shift_vec(8'd3, 4);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k <= 6; k++) begin
      if (k == 2) check(a_so == 1'b1, "R4 readback inner bit", a_so, 1);
      if (k == 6) check(a_so == 1'b1, "R4 readback outer bit", a_so, 1);
      if (k < 6) step(1'b0, 1'b1, 1'b0, 1'b0);
    end
    measure(len);
    check(len == 7, "R8 chain length with both open", len, 7);

    // R10: capture and update together swap the stages
    shift_vec(8'd0, 7);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    shift_vec(8'd1, 1);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    measure(len);
    check(len == 4, "R10 chain length after capture with update", len, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule